// File: doc/BRIEF.md
# Categorized Serial Settings Loader

This block is the control port of an image-sensor analog front end. A host shifts a 16-bit command word into it over three wires: a serial clock, an active-low load strobe, and serial data. On the rising edge of the strobe the word is committed. The strobe event then crosses into the conversion clock domain. A fixed number of conversion clock cycles later, the word's payload is written into one of four setting registers: the standby switch, the programmable gain code, the black-level clamp code, or the input pulse polarity code.

Only one category is updated per word. Which register is written is chosen by a three-bit field in the word. The update is always applied in the conversion domain, so the conversion clock must be running for any setting to take effect. If a new strobe arrives while an earlier word is still waiting, the earlier word is dropped and the delay starts again. A host sending several categories therefore has to wait for each to land, and the busy output tells it when the last one has been applied.

Top module: `afe_serial_loader`

## Requirements
- R1: Serial data is sampled on each rising edge of `sclk` while `sen_n` is low, least-significant bit first; if more than 16 bits are shifted, only the last 16 are kept.
- R2: A word is committed only on the rising edge of `sen_n`; shifting alone changes no output and does not raise `busy`.
- R3: A committed word takes effect on the 6th rising edge of `conv_clk` after the strobe's rising edge, and not before.
- R4: Word bits [3:1] pick the category: 000 sets `standby` from bit 4 (1 = standby, 0 = normal); 001 sets `gain` from bits [15:6]; 010 sets `clamp_level` from bits [15:8]; 011 sets `polarity` from bits [7:4]. The other three registers keep their values.
- R5: A word with bit 0 set, or with category 100 to 111, changes no setting register.
- R6: A strobe that arrives before the previous word has been applied discards that word and restarts the delay, so only the newest word is applied.
- R7: While `conv_clk` is stopped, no committed word is applied. Once the clock runs again, the word lands on its 6th rising edge.
- R8: `busy` is high from the first `conv_clk` rising edge after a strobe until the edge that applies the word, and is low after that edge.
- R9: While `rst_n` is low, and after its release, the block is in normal mode with gain 0, clamp 0, polarity 0 and `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| sclk | input | 1 | Serial shift clock |
| sen_n | input | 1 | Load strobe; low while shifting, rising edge commits the word |
| sdata | input | 1 | Serial data, least-significant bit first |
| conv_clk | input | 1 | Conversion clock that times and applies updates |
| standby | output | 1 | 1 = standby mode, 0 = normal operation |
| gain | output | 10 | Programmable gain code |
| clamp_level | output | 8 | Black-level clamp code |
| polarity | output | 4 | Input pulse polarity selects |
| busy | output | 1 | A committed word is still waiting to be applied |

## Verification
Every setting result is due on the 6th `conv_clk` rising edge after the strobe. The bench raises the strobe 1 ns after a clock edge, so the edge that follows is clearly the first one. It then samples 1 ns after edge 5, where both the old setting values and a high `busy` must still be visible, and again 1 ns after edge 6, where the new values must be present and `busy` must be low. For the stopped-clock case the same edge count starts from the first edge after the clock restarts. For the overriding case it starts from the second strobe, and the first word must never appear.

// File: rtl/afe_ser_pkg.sv
`timescale 1ns/1ps
package afe_ser_pkg;
  localparam int WORD_W    = 16;
  localparam int TEST_BIT  = 0;
  localparam int CAT_LSB   = 1;
  localparam int CAT_W     = 3;
  localparam int STBY_BIT  = 4;
  localparam int GAIN_LSB  = 6;
  localparam int GAIN_W    = 10;
  localparam int CLAMP_LSB = 8;
  localparam int CLAMP_W   = 8;
  localparam int POL_LSB   = 4;
  localparam int POL_W     = 4;

  typedef enum logic [CAT_W-1:0] {
    CAT_STBY  = 3'd0,
    CAT_GAIN  = 3'd1,
    CAT_CLAMP = 3'd2,
    CAT_POL   = 3'd3
  } cat_e;

  typedef struct packed {
    logic               standby;
    logic [GAIN_W-1:0]  gain;
    logic [CLAMP_W-1:0] clamp;
    logic [POL_W-1:0]   pol;
  } settings_t;
endpackage

// File: rtl/afe_rst_sync.sv
`timescale 1ns/1ps
module afe_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/afe_ser_capture.sv
`timescale 1ns/1ps
module afe_ser_capture
  import afe_ser_pkg::*;
(
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sen_n,
  input  logic              sdata,
  output logic [WORD_W-1:0] word_q,
  output logic              evt_tog
);
  logic [WORD_W-1:0] sr_q, sr_d;
  logic              shift_en;

  // shift enable written out: active only while the strobe is low
  assign shift_en = ~sen_n;

  always_comb begin
    sr_d = sr_q;
    if (shift_en) sr_d = {sdata, sr_q[WORD_W-1:1]};
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  // commit register clocked by the strobe edge itself
  always_ff @(posedge sen_n or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      evt_tog <= 1'b0;
    end else begin
      word_q  <= sr_q;
      evt_tog <= ~evt_tog;
    end
  end

  assert_shift_in_R1: assert property (@(posedge sclk) disable iff (!rst_n)
    !sen_n |=> sr_q[WORD_W-1] == $past(sdata));

  assert_commit_word_R2: assert property (@(posedge sen_n) disable iff (!rst_n)
    rst_n |=> word_q == $past(sr_q));

  assert_commit_toggle_R2: assert property (@(posedge sen_n) disable iff (!rst_n)
    rst_n |=> evt_tog != $past(evt_tog));
endmodule

// File: rtl/afe_evt_delay.sv
`timescale 1ns/1ps
module afe_evt_delay
  import afe_ser_pkg::*;
#(
  parameter int DELAY       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_tog_async,
  input  logic [WORD_W-1:0] word_async,
  output logic [WORD_W-1:0] pend_word,
  output logic              apply,
  output logic              busy
);
  localparam int LOAD  = DELAY - SYNC_STAGES - 1;
  localparam int CNT_W = (LOAD < 2) ? 1 : $clog2(LOAD + 1);

  logic [SYNC_STAGES:0] sync_q;
  logic                 evt;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [WORD_W-1:0]    pend_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q[0] <= 1'b0;
    else        sync_q[0] <= evt_tog_async;
  end

  for (genvar i = 1; i <= SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[i] <= 1'b0;
      else        sync_q[i] <= sync_q[i-1];
    end
  end

  assign evt = sync_q[SYNC_STAGES-1] ^ sync_q[SYNC_STAGES];

  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pend_word;
    if (evt) begin
      cnt_d  = CNT_W'(LOAD);
      pend_d = word_async;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      pend_word <= '0;
    end else begin
      cnt_q     <= cnt_d;
      pend_word <= pend_d;
    end
  end

  assign apply = (cnt_q == CNT_W'(1)) && !evt;
  assign busy  = (sync_q[0] ^ sync_q[SYNC_STAGES]) || (cnt_q != '0);

  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> cnt_q == CNT_W'(LOAD));

  assert_countdown_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !evt) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(LOAD));

  assert_busy_apply_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && !busy) |-> 1'b0);
endmodule

// File: rtl/afe_setting_regs.sv
`timescale 1ns/1ps
module afe_setting_regs
  import afe_ser_pkg::*;
#(
  parameter logic [POL_W-1:0] POL_RESET = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              apply,
  input  logic [WORD_W-1:0] word,
  output settings_t         cfg
);
  settings_t  cfg_d;
  logic       valid;
  cat_e       cat;
  logic       we_stby, we_gain, we_clamp, we_pol;
  logic       unused_bits;

  assign valid = ~word[TEST_BIT];
  assign cat   = cat_e'(word[CAT_LSB +: CAT_W]);
  assign unused_bits = word[5];

  always_comb begin
    we_stby  = 1'b0;
    we_gain  = 1'b0;
    we_clamp = 1'b0;
    we_pol   = 1'b0;
    if (apply && valid) begin
      case (cat)
        CAT_STBY:  we_stby  = 1'b1;
        CAT_GAIN:  we_gain  = 1'b1;
        CAT_CLAMP: we_clamp = 1'b1;
        CAT_POL:   we_pol   = 1'b1;
        default:   ;
      endcase
    end
  end

  always_comb begin
    cfg_d = cfg;
    if (we_stby)  cfg_d.standby = word[STBY_BIT];
    if (we_gain)  cfg_d.gain    = word[GAIN_LSB  +: GAIN_W];
    if (we_clamp) cfg_d.clamp   = word[CLAMP_LSB +: CLAMP_W];
    if (we_pol)   cfg_d.pol     = word[POL_LSB   +: POL_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.standby <= 1'b0;
      cfg.gain    <= '0;
      cfg.clamp   <= '0;
      cfg.pol     <= POL_RESET;
    end else begin
      cfg <= cfg_d;
    end
  end

  assert_one_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({we_stby, we_gain, we_clamp, we_pol}));

  assert_gain_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && !word[TEST_BIT] && word[CAT_LSB +: CAT_W] == 3'd1)
      |=> cfg.gain == $past(word[GAIN_LSB +: GAIN_W]) && $stable(cfg.clamp));

  assert_test_bit_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && word[TEST_BIT]) |=> $stable(cfg));

  assert_hold_no_apply_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable(cfg));
endmodule

// File: rtl/afe_serial_loader.sv
`timescale 1ns/1ps
module afe_serial_loader
  import afe_ser_pkg::*;
#(
  parameter int                DELAY       = 6,
  parameter int                SYNC_STAGES = 2,
  parameter logic [POL_W-1:0]  POL_RESET   = '0
) (
  input  logic               rst_n,
  input  logic               sclk,
  input  logic               sen_n,
  input  logic               sdata,
  input  logic               conv_clk,
  output logic               standby,
  output logic [GAIN_W-1:0]  gain,
  output logic [CLAMP_W-1:0] clamp_level,
  output logic [POL_W-1:0]   polarity,
  output logic               busy
);
  logic [WORD_W-1:0] word_cap;
  logic [WORD_W-1:0] word_pend;
  logic              tog;
  logic              conv_rst_n;
  logic              apply;
  settings_t         cfg;

  afe_rst_sync #(.STAGES(2)) u_rst (
    .clk        (conv_clk),
    .arst_n     (rst_n),
    .rst_n_sync (conv_rst_n)
  );

  afe_ser_capture u_cap (
    .rst_n   (rst_n),
    .sclk    (sclk),
    .sen_n   (sen_n),
    .sdata   (sdata),
    .word_q  (word_cap),
    .evt_tog (tog)
  );

  afe_evt_delay #(.DELAY(DELAY), .SYNC_STAGES(SYNC_STAGES)) u_dly (
    .clk           (conv_clk),
    .rst_n         (conv_rst_n),
    .evt_tog_async (tog),
    .word_async    (word_cap),
    .pend_word     (word_pend),
    .apply         (apply),
    .busy          (busy)
  );

  afe_setting_regs #(.POL_RESET(POL_RESET)) u_regs (
    .clk   (conv_clk),
    .rst_n (conv_rst_n),
    .apply (apply),
    .word  (word_pend),
    .cfg   (cfg)
  );

  assign standby     = cfg.standby;
  assign gain        = cfg.gain;
  assign clamp_level = cfg.clamp;
  assign polarity    = cfg.pol;

  assert_reset_state_R9: assert property (@(posedge conv_clk)
    !conv_rst_n |-> (!standby && gain == '0 && clamp_level == '0 && !busy));
endmodule

// File: tb/sim_afe_serial_loader.sv
`timescale 1ns/1ps
module sim_afe_serial_loader;
  logic        rst_n, sclk, sen_n, sdata, clk, clk_run;
  logic        standby, busy;
  logic [9:0]  gain;
  logic [7:0]  clamp_level;
  logic [3:0]  polarity;
  logic [22:0] exp_q;
  int          n_chk, n_bad;
  bit          done;

  afe_serial_loader u0 (
    .rst_n(rst_n), .sclk(sclk), .sen_n(sen_n), .sdata(sdata), .conv_clk(clk),
    .standby(standby), .gain(gain), .clamp_level(clamp_level),
    .polarity(polarity), .busy(busy)
  );

  initial clk = 1'b0;
  always #2.5 clk = clk_run ? ~clk : 1'b0;

  function automatic logic [22:0] outs();
    return {standby, gain, clamp_level, polarity};
  endfunction

  function automatic logic [22:0] model(logic [22:0] cur, logic [15:0] w);
    logic [22:0] n = cur;
    if (w[0]) return cur;
    case (w[3:1])
      3'd0: n[22]    = w[4];
      3'd1: n[21:12] = w[15:6];
      3'd2: n[11:4]  = w[15:8];
      3'd3: n[3:0]   = w[7:4];
      default: ;
    endcase
    return n;
  endfunction

  task automatic chk(string req, logic [22:0] act, logic [22:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift(logic [31:0] bits, int n, realtime half);
    sen_n = 1'b0;
    for (int i = 0; i < n; i++) begin
      sdata = bits[i];
      #(half) sclk = 1'b1;
      #(half) sclk = 1'b0;
    end
  endtask

  task automatic strobe();
    @(posedge clk); #1 sen_n = 1'b1;
  endtask

  // strobe already raised; check edge 5 (old) and edge 6 (new)
  task automatic due(logic [15:0] w, string req);
    repeat (5) @(posedge clk);
    #1;
    chk({req, " before edge 6 (R3)"}, outs(), exp_q);
    chk("busy held (R8)", {22'd0, busy}, 23'd1);
    @(posedge clk); #1;
    exp_q = model(exp_q, w);
    chk({req, " at edge 6 (R3)"}, outs(), exp_q);
    chk("busy cleared (R8)", {22'd0, busy}, 23'd0);
  endtask

  task automatic xfer(logic [15:0] w, string req);
    shift({16'd0, w}, 16, 5.0);
    strobe();
    due(w, req);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 0;
    rst_n = 1'b0; sclk = 1'b0; sen_n = 1'b1; sdata = 1'b0; clk_run = 1'b1;
    exp_q = '0;
    #21;
    chk("R9 reset state", outs(), 23'd0);
    chk("R9 busy in reset", {22'd0, busy}, 23'd0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 chk("R9 after release", {outs()}, 23'd0);

    // R4 gain sweep
    for (int i = 0; i < 32; i++) begin
      logic [9:0] g = 10'((i * 33 + 5) & 1023);
      xfer({g, 2'b00, 3'b001, 1'b0}, "R4 gain");
    end

    // R4/R5 sweep over every category code and test bit
    for (int c = 0; c < 8; c++) begin
      for (int t = 0; t < 2; t++) begin
        logic [11:0] p = 12'((c * 1187 + t * 311 + 97) & 12'hfff);
        xfer({p, 3'(c), 1'(t)}, (t == 0 && c < 4) ? "R4 category" : "R5 ignored word");
      end
    end
    xfer(16'h0010, "R4 standby on");
    xfer(16'h0000, "R4 standby off");

    // R1: 20 bits shifted, last 16 kept
    begin
      logic [19:0] b = {16'b1010_1100_1100_0100, 4'b1111};
      shift({12'd0, b}, 20, 5.0);
      strobe();
      due(b[19:4], "R1 overlong word");
    end

    // R2: shifting without strobe does nothing
    shift({16'd0, 16'h7F82}, 16, 5.0);
    repeat (20) @(posedge clk);
    #1 chk("R2 no commit without strobe", outs(), exp_q);
    chk("R2 busy idle", {22'd0, busy}, 23'd0);
    strobe();
    due(16'h7F82, "R2 committed on rise");

    // R6: second word overrides first before it lands
    shift({16'd0, 16'hABC2}, 16, 5.0);
    strobe();
    #0.5;
    shift({16'd0, 16'h5A04}, 16, 0.2);
    strobe();
    due(16'h5A04, "R6 newest word only");
    repeat (10) @(posedge clk);
    #1 chk("R6 first word never lands", outs(), exp_q);

    // R7: stopped conversion clock
    clk_run = 1'b0;
    #10;
    shift({16'd0, 16'h00F6}, 16, 5.0);
    #3 sen_n = 1'b1;
    #100;
    chk("R7 no apply while stopped", outs(), exp_q);
    clk_run = 1'b1;
    due(16'h00F6, "R7 after restart");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule